// File: doc/BRIEF.md
# Audio DAC Serial Control Register Block

This block is the write-only configuration port of a stereo audio DAC. A host shifts 16-bit control words in over three wires: a serial clock, a serial data line and a latch strobe. The two top bits of a word choose the target register. Three registers exist: the left volume, the right volume and the operating mode. The lower 14 bits carry the payload. The block keeps the volume codes for the attenuator downstream. It also produces the decoded operating controls: serial interface format, data width for right-justified input, interpolation ratio, de-emphasis, mute and power-down.

Every operating control except the right-justified width also has an external strap pin. The effective control is the logical OR of the pin and the programmed bit, so a pin must be tied low before software can take that control over. The interpolation select has one prohibited code. When the merged value lands on it, the block raises an error flag and keeps the last legal ratio.

The serial lines are asynchronous to the system clock. The block synchronises them and detects their edges before use. All outputs are registered.

Top module: `dac_ctrl_regs`

## Requirements
- R1: A synchronous reset (`rst_i` high) sets both volume outputs to full scale (all 14 bits ones). It clears every mode register bit. After reset, `fmt_o`, `interp_o`, `deemph_o`, `mute_o`, `pwrdn_o` and `interp_err_o` read 0 and `rj_bits_o` reads 24, provided the pins are low.
- R2: Data is shifted in MSB first, one bit per rising edge of `ser_clk_i`. Shifting alone changes no register. A rising edge of `ser_lat_i` commits the last 16 bits shifted in, even when no clocks came since the previous commit.
- R3: A committed word whose bits [15:14] are 00 loads bits [13:0] into `vol_left_o`.
- R4: A committed word whose bits [15:14] are 01 loads bits [13:0] into `vol_right_o`.
- R5: A committed word whose bits [15:14] are 10 loads the mode register. Its fields are: format in [1:0], right-justified width code in [3:2], interpolation select in [5:4], de-emphasis in [6], mute in [7] and power-down in [8]. Bits [13:9] are ignored.
- R6: A committed word whose bits [15:14] are 11 changes no output.
- R7: `fmt_o`, `interp_o` (when legal), `deemph_o`, `mute_o` and `pwrdn_o` equal the bitwise OR of the matching pin and register field, one clock after the inputs settle. The format codes are: 00 right-justified, 01 I2S, 10 left-justified, 11 DSP.
- R8: `rj_bits_o` decodes the width code: 00 gives 24, 01 gives 20, 10 gives 16, 11 gives 24.
- R9: The interpolation codes are 00 for 8x, 01 for 4x and 10 for 2x. If the OR-merged select is 11, `interp_err_o` is 1 and `interp_o` keeps its last legal value. Once the merge is legal again, the flag clears and `interp_o` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ser_clk_i | input | 1 | Serial shift clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, MSB first |
| ser_lat_i | input | 1 | Latch strobe; rising edge commits the word |
| pin_fmt_i | input | 2 | External format strap pins |
| pin_interp_i | input | 2 | External interpolation strap pins |
| pin_deemph_i | input | 1 | External de-emphasis pin |
| pin_mute_i | input | 1 | External mute pin |
| pin_pwrdn_i | input | 1 | External power-down pin |
| vol_left_o | output | 14 | Left channel volume code |
| vol_right_o | output | 14 | Right channel volume code |
| fmt_o | output | 2 | Effective serial interface format |
| interp_o | output | 2 | Effective interpolation select, always legal |
| interp_err_o | output | 1 | Prohibited interpolation code present |
| deemph_o | output | 1 | Effective de-emphasis enable |
| mute_o | output | 1 | Effective mute |
| pwrdn_o | output | 1 | Effective power-down |
| rj_bits_o | output | 5 | Right-justified word width in bits |

## Verification
The properties assume two things about the inputs. The strap pins are quasi-static. Each level on the serial lines is held for more than the synchroniser depth in system clocks, and the data line is stable around each rising serial clock. The stimulus meets both. It holds every serial level for three system clocks and changes data only while the serial clock is low. It changes pins only between whole words and then waits several cycles before sampling. Under these conditions the volume outputs may change only in the cycle after a detected latch edge. The merged controls must also cover the pin values of the previous cycle.

// File: rtl/dac_ctrl_pkg.sv
package dac_ctrl_pkg;

    localparam int WORD_W = 16;
    localparam int ADDR_W = 2;
    localparam int VOL_W  = WORD_W - ADDR_W;
    localparam int BITS_W = 5;

    // mode word field positions
    localparam int MF_FMT    = 0;
    localparam int MF_WID    = 2;
    localparam int MF_INTERP = 4;
    localparam int MF_DEEMPH = 6;
    localparam int MF_MUTE   = 7;
    localparam int MF_PWRDN  = 8;

    typedef enum logic [ADDR_W-1:0] {
        ADR_VOL_L = 2'b00,
        ADR_VOL_R = 2'b01,
        ADR_MODE  = 2'b10,
        ADR_NONE  = 2'b11
    } reg_addr_e;

    typedef enum logic [1:0] {
        FMT_RJ  = 2'b00,
        FMT_I2S = 2'b01,
        FMT_LJ  = 2'b10,
        FMT_DSP = 2'b11
    } fmt_e;

    localparam logic [1:0] INTERP_BAD = 2'b11;

    typedef struct packed {
        logic [1:0] fmt;
        logic [1:0] width;
        logic [1:0] interp;
        logic       deemph;
        logic       mute;
        logic       pwrdn;
    } mode_t;

endpackage

// File: rtl/dac_in_sync.sv
module dac_in_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);

    logic [STAGES-1:0][N-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = async_i;
        for (int k = 1; k < STAGES; k++) begin
            stg_d[k] = stg_q[k-1];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/dac_ser_shift.sv
module dac_ser_shift #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         shift_en_i,
    input  logic         bit_i,
    output logic [W-1:0] word_o
);

    logic [W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (shift_en_i) begin
            sr_d = {sr_q[W-2:0], bit_i};
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end

    assign word_o = sr_q;

endmodule

// File: rtl/dac_mode_merge.sv
module dac_mode_merge
    import dac_ctrl_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  mode_t             reg_mode_i,
    input  logic [1:0]        pin_fmt_i,
    input  logic [1:0]        pin_interp_i,
    input  logic              pin_deemph_i,
    input  logic              pin_mute_i,
    input  logic              pin_pwrdn_i,
    output logic [1:0]        fmt_o,
    output logic [1:0]        interp_o,
    output logic              interp_err_o,
    output logic              deemph_o,
    output logic              mute_o,
    output logic              pwrdn_o,
    output logic [BITS_W-1:0] rj_bits_o
);

    typedef struct packed {
        logic [1:0]        fmt;
        logic [1:0]        interp;
        logic              err;
        logic              deemph;
        logic              mute;
        logic              pwrdn;
        logic [BITS_W-1:0] rj_bits;
    } eff_t;

    eff_t eff_d, eff_q;
    logic [1:0] interp_raw;

    function automatic logic [BITS_W-1:0] width_bits(input logic [1:0] code);
        case (code)
            2'b01:   width_bits = BITS_W'(20);
            2'b10:   width_bits = BITS_W'(16);
            default: width_bits = BITS_W'(24);
        endcase
    endfunction

    always_comb begin
        eff_d        = eff_q;
        interp_raw   = pin_interp_i | reg_mode_i.interp;
        eff_d.fmt    = pin_fmt_i | reg_mode_i.fmt;
        eff_d.deemph = pin_deemph_i | reg_mode_i.deemph;
        eff_d.mute   = pin_mute_i | reg_mode_i.mute;
        eff_d.pwrdn  = pin_pwrdn_i | reg_mode_i.pwrdn;
        eff_d.rj_bits = width_bits(reg_mode_i.width);
        eff_d.err    = (interp_raw == INTERP_BAD);
        if (interp_raw != INTERP_BAD) begin
            eff_d.interp = interp_raw;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            eff_q         <= '0;
            eff_q.rj_bits <= BITS_W'(24);
        end else begin
            eff_q <= eff_d;
        end
    end

    assign fmt_o        = eff_q.fmt;
    assign interp_o     = eff_q.interp;
    assign interp_err_o = eff_q.err;
    assign deemph_o     = eff_q.deemph;
    assign mute_o       = eff_q.mute;
    assign pwrdn_o      = eff_q.pwrdn;
    assign rj_bits_o    = eff_q.rj_bits;

endmodule

// File: rtl/dac_ctrl_regs.sv
module dac_ctrl_regs
    import dac_ctrl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              ser_clk_i,
    input  logic              ser_dat_i,
    input  logic              ser_lat_i,
    input  logic [1:0]        pin_fmt_i,
    input  logic [1:0]        pin_interp_i,
    input  logic              pin_deemph_i,
    input  logic              pin_mute_i,
    input  logic              pin_pwrdn_i,
    output logic [VOL_W-1:0]  vol_left_o,
    output logic [VOL_W-1:0]  vol_right_o,
    output logic [1:0]        fmt_o,
    output logic [1:0]        interp_o,
    output logic              interp_err_o,
    output logic              deemph_o,
    output logic              mute_o,
    output logic              pwrdn_o,
    output logic [BITS_W-1:0] rj_bits_o
);

    localparam int              N_SER    = 3;
    localparam logic [VOL_W-1:0] VOL_FULL = '1;

    typedef struct packed {
        logic             sclk_prev;
        logic             slat_prev;
        logic [VOL_W-1:0] vol_l;
        logic [VOL_W-1:0] vol_r;
        mode_t            mode;
    } state_t;

    state_t st_d, st_q;

    logic [N_SER-1:0]  ser_sync;
    logic              sclk_rise;
    logic              lat_rise;
    logic [WORD_W-1:0] shift_word;
    reg_addr_e         word_addr;

    dac_in_sync #(
        .N      (N_SER),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .async_i ({ser_lat_i, ser_dat_i, ser_clk_i}),
        .sync_o  (ser_sync)
    );

    assign sclk_rise = ser_sync[0] & ~st_q.sclk_prev;
    assign lat_rise  = ser_sync[2] & ~st_q.slat_prev;

    dac_ser_shift #(
        .W (WORD_W)
    ) shift_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .shift_en_i (sclk_rise),
        .bit_i      (ser_sync[1]),
        .word_o     (shift_word)
    );

    assign word_addr = reg_addr_e'(shift_word[WORD_W-1 -: ADDR_W]);

    always_comb begin
        st_d           = st_q;
        st_d.sclk_prev = ser_sync[0];
        st_d.slat_prev = ser_sync[2];
        if (lat_rise) begin
            case (word_addr)
                ADR_VOL_L: st_d.vol_l = shift_word[VOL_W-1:0];
                ADR_VOL_R: st_d.vol_r = shift_word[VOL_W-1:0];
                ADR_MODE: begin
                    st_d.mode.fmt    = shift_word[MF_FMT +: 2];
                    st_d.mode.width  = shift_word[MF_WID +: 2];
                    st_d.mode.interp = shift_word[MF_INTERP +: 2];
                    st_d.mode.deemph = shift_word[MF_DEEMPH];
                    st_d.mode.mute   = shift_word[MF_MUTE];
                    st_d.mode.pwrdn  = shift_word[MF_PWRDN];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q       <= '0;
            st_q.vol_l <= VOL_FULL;
            st_q.vol_r <= VOL_FULL;
        end else begin
            st_q <= st_d;
        end
    end

    assign vol_left_o  = st_q.vol_l;
    assign vol_right_o = st_q.vol_r;

    dac_mode_merge merge_i (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .reg_mode_i   (st_q.mode),
        .pin_fmt_i    (pin_fmt_i),
        .pin_interp_i (pin_interp_i),
        .pin_deemph_i (pin_deemph_i),
        .pin_mute_i   (pin_mute_i),
        .pin_pwrdn_i  (pin_pwrdn_i),
        .fmt_o        (fmt_o),
        .interp_o     (interp_o),
        .interp_err_o (interp_err_o),
        .deemph_o     (deemph_o),
        .mute_o       (mute_o),
        .pwrdn_o      (pwrdn_o),
        .rj_bits_o    (rj_bits_o)
    );

endmodule

// File: rtl/dac_ctrl_chk.sv
module dac_ctrl_chk
    import dac_ctrl_pkg::*;
(
    input logic              clk_i,
    input logic              rst_i,
    input logic              lat_rise,
    input logic [1:0]        pin_fmt_i,
    input logic              pin_deemph_i,
    input logic              pin_mute_i,
    input logic              pin_pwrdn_i,
    input logic [VOL_W-1:0]  vol_left_o,
    input logic [VOL_W-1:0]  vol_right_o,
    input logic [1:0]        fmt_o,
    input logic [1:0]        interp_o,
    input logic              interp_err_o,
    input logic              deemph_o,
    input logic              mute_o,
    input logic              pwrdn_o,
    input logic [BITS_W-1:0] rj_bits_o
);

    // R1
    reset_state_chk: assert property (@(posedge clk_i)
        ($past(rst_i) && !rst_i) |-> (vol_left_o == '1 && vol_right_o == '1 &&
                                      !interp_err_o && interp_o == 2'b00 &&
                                      rj_bits_o == BITS_W'(24)));

    // R3
    vol_left_commit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(!rst_i) && vol_left_o != $past(vol_left_o)) |-> $past(lat_rise));

    // R4
    vol_right_commit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(!rst_i) && vol_right_o != $past(vol_right_o)) |-> $past(lat_rise));

    // R7
    fmt_or_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(!rst_i) |-> ((fmt_o & $past(pin_fmt_i)) == $past(pin_fmt_i)));

    // R7
    mute_or_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(!rst_i) && $past(pin_mute_i)) |-> mute_o);

    // R7
    deemph_or_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(!rst_i) && $past(pin_deemph_i)) |-> deemph_o);

    // R7
    pwrdn_or_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(!rst_i) && $past(pin_pwrdn_i)) |-> pwrdn_o);

    // R8
    rj_width_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (rj_bits_o == BITS_W'(16) || rj_bits_o == BITS_W'(20) || rj_bits_o == BITS_W'(24)));

    // R9
    interp_legal_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        interp_o != 2'b11);

    // R9
    interp_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (interp_err_o && $past(!rst_i)) |-> interp_o == $past(interp_o));

endmodule

bind dac_ctrl_regs dac_ctrl_chk chk_i (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .lat_rise     (lat_rise),
    .pin_fmt_i    (pin_fmt_i),
    .pin_deemph_i (pin_deemph_i),
    .pin_mute_i   (pin_mute_i),
    .pin_pwrdn_i  (pin_pwrdn_i),
    .vol_left_o   (vol_left_o),
    .vol_right_o  (vol_right_o),
    .fmt_o        (fmt_o),
    .interp_o     (interp_o),
    .interp_err_o (interp_err_o),
    .deemph_o     (deemph_o),
    .mute_o       (mute_o),
    .pwrdn_o      (pwrdn_o),
    .rj_bits_o    (rj_bits_o)
);

// File: tb/dac_ctrl_regs_tb.sv
`timescale 1ns/1ps
module dac_ctrl_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b0, sdat = 1'b0, slat = 1'b0;
    logic [1:0]  p_fmt = '0, p_interp = '0;
    logic        p_de = 1'b0, p_mu = 1'b0, p_pd = 1'b0;
    logic [13:0] vol_l, vol_r;
    logic [1:0]  fmt, interp;
    logic        ierr, de, mu, pd;
    logic [4:0]  rjb;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // bench model of the interpolation path
    logic [1:0] m_reg_interp = 2'b00;
    logic [1:0] m_legal      = 2'b00;
    logic       m_err        = 1'b0;

    always #2.5 clk = ~clk;

    dac_ctrl_regs dut_i (
        .clk_i (clk), .rst_i (rst),
        .ser_clk_i (sclk), .ser_dat_i (sdat), .ser_lat_i (slat),
        .pin_fmt_i (p_fmt), .pin_interp_i (p_interp),
        .pin_deemph_i (p_de), .pin_mute_i (p_mu), .pin_pwrdn_i (p_pd),
        .vol_left_o (vol_l), .vol_right_o (vol_r),
        .fmt_o (fmt), .interp_o (interp), .interp_err_o (ierr),
        .deemph_o (de), .mute_o (mu), .pwrdn_o (pd), .rj_bits_o (rjb)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic shift_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) begin
            sclk = 1'b0; sdat = w[i];
            tick(3);
            sclk = 1'b1;
            tick(3);
        end
        sclk = 1'b0;
        tick(3);
    endtask

    task automatic latch();
        slat = 1'b1; tick(4);
        slat = 1'b0; tick(8);
    endtask

    task automatic model_interp(input logic [1:0] raw);
        m_err = (raw == 2'b11);
        if (raw != 2'b11) m_legal = raw;
    endtask

    task automatic write_mode(input logic [1:0] f, input logic [1:0] w, input logic [1:0] ip,
                              input logic d, input logic m, input logic p);
        shift_word({2'b10, 5'b10101, p, m, d, ip, w, f});
        latch();
        m_reg_interp = ip;
        model_interp(p_interp | ip);
    endtask

    task automatic set_pins(input logic [1:0] f, input logic [1:0] ip,
                            input logic d, input logic m, input logic p);
        p_fmt = f; p_interp = ip; p_de = d; p_mu = m; p_pd = p;
        tick(4);
        model_interp(ip | m_reg_interp);
    endtask

    initial begin
        tick(5);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        check("R1", "vol_left", vol_l, 16'h3FFF);
        check("R1", "vol_right", vol_r, 16'h3FFF);
        check("R1", "fmt", fmt, 0);
        check("R1", "interp", interp, 0);
        check("R1", "interp_err", ierr, 0);
        check("R1", "deemph", de, 0);
        check("R1", "mute", mu, 0);
        check("R1", "pwrdn", pd, 0);
        check("R1", "rj_bits", rjb, 24);

        // R2 shifting alone commits nothing; a bare latch commits held word
        shift_word({2'b00, 14'h1234});
        tick(6);
        check("R2", "vol_left before latch", vol_l, 16'h3FFF);
        latch();
        check("R2", "vol_left after latch", vol_l, 16'h1234);
        latch();
        check("R2", "vol_left repeat latch", vol_l, 16'h1234);

        // R3 R4 volume sweep, walking bits and complements
        for (int k = 0; k < 14; k++) begin
            logic [13:0] v;
            v = 14'(1) << k;
            shift_word({2'b00, v});  latch();
            shift_word({2'b01, ~v}); latch();
            check("R3", "vol_left sweep", vol_l, int'(v));
            check("R4", "vol_right sweep", vol_r, int'(14'(~v)));
        end

        // R6 address 11 ignored
        write_mode(2'b01, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0);
        shift_word({2'b11, 14'h3FFF});
        latch();
        check("R6", "vol_left kept", vol_l, 16'h2000);
        check("R6", "vol_right kept", vol_r, int'(14'(~14'h2000)));
        check("R6", "fmt kept", fmt, 1);
        check("R6", "mute kept", mu, 0);
        check("R6", "pwrdn kept", pd, 0);

        // R5 R7 format sweep: pin x register
        for (int p = 0; p < 4; p++) begin
            for (int r = 0; r < 4; r++) begin
                set_pins(2'(p), 2'b00, 1'b0, 1'b0, 1'b0);
                write_mode(2'(r), 2'b00, 2'b00, 1'b0, 1'b0, 1'b0);
                check("R7", "fmt or", fmt, p | r);
            end
        end

        // R5 R7 single-bit controls sweep
        for (int p = 0; p < 8; p++) begin
            for (int r = 0; r < 8; r++) begin
                set_pins(2'b00, 2'b00, p[0], p[1], p[2]);
                write_mode(2'b00, 2'b00, 2'b00, r[0], r[1], r[2]);
                check("R7", "deemph or", de, p[0] | r[0]);
                check("R7", "mute or", mu, p[1] | r[1]);
                check("R7", "pwrdn or", pd, p[2] | r[2]);
            end
        end
        set_pins(2'b00, 2'b00, 1'b0, 1'b0, 1'b0);

        // R8 width decode
        for (int w = 0; w < 4; w++) begin
            int exp_bits;
            exp_bits = (w == 1) ? 20 : (w == 2) ? 16 : 24;
            write_mode(2'b00, 2'(w), 2'b00, 1'b0, 1'b0, 1'b0);
            check("R8", "rj_bits", rjb, exp_bits);
        end

        // R9 interpolation sweep with last-legal tracking
        for (int p = 0; p < 4; p++) begin
            for (int r = 0; r < 4; r++) begin
                set_pins(2'b00, 2'(p), 1'b0, 1'b0, 1'b0);
                check("R9", "interp after pin", interp, m_legal);
                check("R9", "err after pin", ierr, m_err);
                write_mode(2'b00, 2'b00, 2'(r), 1'b0, 1'b0, 1'b0);
                check("R9", "interp after write", interp, m_legal);
                check("R9", "err after write", ierr, m_err);
            end
        end
        set_pins(2'b00, 2'b00, 1'b0, 1'b0, 1'b0);
        write_mode(2'b00, 2'b00, 2'b01, 1'b0, 1'b0, 1'b0);
        check("R9", "interp recovers", interp, 1);
        check("R9", "err clears", ierr, 0);

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule